// File: doc/BRIEF.md
# I2C Two-Stage Bus Clock Generator

This block produces the timing strobes an I2C controller needs, starting from the system clock. A single control byte, written by software and never read back, selects two divider settings. The first is a 3-bit exponent `N` that sets a power-of-two prescaler. That prescaler emits a one-cycle bus-sampling strobe every 2^N system clocks. The second is a 4-bit scalar `M`. It sets how many sampling strobes make up one master-mode SCL period: ten times (M+1).

Because the two settings are independent, the rate at which the bus is sampled can stay well above the rate of the clock this node drives as a master. Keeping the sampling rate at least ten times the fastest master's SCL rate ensures that START and STOP conditions are never missed.

The controller around this block consumes the sample strobe, the SCL level and the single-cycle SCL edge strobes. It owns all read data at the shared register address, so this block drives none.

Top module: `i2c_clkgen`

## Requirements
- R1: After reset the stored exponent and scalar are both zero. With the master enable low, the sample strobe is high on every cycle, SCL is high, and neither edge strobe is asserted.
- R2: In the control byte, bits 2:0 give the exponent N and bits 6:3 give the scalar M. Bit 7 has no effect on any output.
- R3: The sample strobe is a single-cycle pulse issued once every 2^N system clocks. With N=0 it is high on every cycle.
- R4: With the master enable high, one SCL period lasts 10·(M+1)·2^N system clocks. SCL is high for the first 5·(M+1) sampling strobes of the period and low for the remaining 5·(M+1).
- R5: A write to the control byte restarts both stages from a clean phase. Count the cycle after the write edge as cycle 0. Then the first sample strobe falls in cycle 2^N−1, SCL is high from cycle 0, the first falling edge is in cycle 5·(M+1)·2^N, and the next rising edge is in cycle 10·(M+1)·2^N.
- R6: The rise strobe is high for exactly the one cycle in which SCL has just gone from low to high, and the fall strobe likewise for a high-to-low change. The two are never high together. A write made while SCL is low therefore produces a rise strobe in cycle 0.
- R7: While the master enable is low, SCL is held high and no edge strobe is issued, even if SCL was low when the enable dropped. The sample strobe keeps its rate and phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | One-cycle write strobe for the control byte |
| cfg_wdata | input | 8 | Control byte: M in 6:3, N in 2:0, bit 7 unused |
| master_en | input | 1 | High while the controller acts as bus master |
| samp_stb | output | 1 | Bus-sampling strobe, once per 2^N clocks |
| scl_o | output | 1 | Generated SCL level (1 = released) |
| scl_rise | output | 1 | One-cycle strobe in the cycle SCL turns high |
| scl_fall | output | 1 | One-cycle strobe in the cycle SCL turns low |

## Verification
The embedded assertions guard the properties that hold on every cycle:
- The edge strobes are mutually exclusive and agree with the SCL level.
- SCL falls only right after a sample strobe.
- A write or a low enable leaves SCL released on the next cycle with no edge strobe.
- The SCL phase counter never leaves its period.

The exact rates, the high/low split and the clean restart after a write depend on counting whole periods. Only the bench's sweep can show them. The sweep covers every scalar value for small exponents plus large-exponent corners, and compares the outputs on every cycle against arithmetic expectations.

// File: rtl/i2c_clkgen.sv
module i2c_clkgen #(
  parameter int EXP_W = 3,
  parameter int MUL_W = 4,
  localparam int CFG_W = EXP_W + MUL_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             master_en,
  output logic             samp_stb,
  output logic             scl_o,
  output logic             scl_rise,
  output logic             scl_fall
);
  localparam int PRE_W = (1 << EXP_W) - 1;
  localparam int CNT_W = $clog2(10 << MUL_W);

  logic [MUL_W-1:0] mul_q;
  logic [EXP_W-1:0] exp_q;
  logic [PRE_W-1:0] pre_q, pre_lim;
  logic [CNT_W-1:0] cnt_q, cnt_nxt, half, last;
  logic             scl_nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mul_q <= '0;
      exp_q <= '0;
    end else if (cfg_we) begin
      mul_q <= cfg_wdata[EXP_W +: MUL_W];
      exp_q <= cfg_wdata[EXP_W-1:0];
    end

  assign pre_lim  = PRE_W'((32'd1 << exp_q) - 32'd1);
  assign samp_stb = (pre_q == pre_lim);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   pre_q <= '0;
    else if (cfg_we || samp_stb)  pre_q <= '0;
    else                          pre_q <= pre_q + 1'b1;

  assign half = CNT_W'((32'(mul_q) + 32'd1) * 32'd5);
  assign last = CNT_W'((32'(mul_q) + 32'd1) * 32'd10 - 32'd1);

  always_comb begin
    if (cfg_we || !master_en) cnt_nxt = '0;
    else if (samp_stb)        cnt_nxt = (cnt_q == last) ? '0 : cnt_q + 1'b1;
    else                      cnt_nxt = cnt_q;
    scl_nxt = !master_en || cfg_we || (cnt_nxt < half);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q    <= '0;
      scl_o    <= 1'b1;
      scl_rise <= 1'b0;
      scl_fall <= 1'b0;
    end else begin
      cnt_q    <= cnt_nxt;
      scl_o    <= scl_nxt;
      scl_rise <= master_en && scl_nxt && !scl_o;
      scl_fall <= master_en && !scl_nxt && scl_o;
    end

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(scl_rise && scl_fall)); // R6
  AST_RISE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) scl_rise |-> scl_o); // R6
  AST_FALL_LOW: assert property (@(posedge clk) disable iff (!rst_n) scl_fall |-> !scl_o); // R6
  AST_FALL_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n) scl_fall |-> $past(samp_stb)); // R4
  AST_WRITE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) cfg_we |=> scl_o && !scl_fall); // R5
  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) !master_en |=> scl_o && !scl_rise && !scl_fall); // R7
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= last); // R4
endmodule

// File: tb/i2c_clkgen_test.sv
module i2c_clkgen_test;
  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0, master_en = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic samp_stb, scl_o, scl_rise, scl_fall;
  int vecs = 0, errs = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  i2c_clkgen uut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
                  .master_en(master_en), .samp_stb(samp_stb), .scl_o(scl_o),
                  .scl_rise(scl_rise), .scl_fall(scl_fall));

  task automatic chk(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  int cur_n, cur_m, c;

  task automatic check_cycle(input bit en, input bit prev_low);
    int p, h, t, ph;
    p = 1 << cur_n;
    h = 5 * (cur_m + 1) * p;
    t = 2 * h;
    ph = c % t;
    chk("R3 samp_stb", samp_stb, ((c % p) == p - 1));
    if (en) begin
      chk("R4 scl_o", scl_o, (ph < h));
      chk("R6 scl_fall", scl_fall, (ph == h));
      chk("R6 scl_rise", scl_rise, (ph == 0) && (c > 0 || prev_low));
    end else begin
      chk("R7 scl_o released", scl_o, 1);
      chk("R7 no rise", scl_rise, 0);
      chk("R7 no fall", scl_fall, 0);
    end
  endtask

  task automatic run_cfg(input int n, input int m, input bit b7, input int len);
    bit prev_low;
    prev_low = master_en && !scl_o;
    cfg_wdata = {b7, 4'(m), 3'(n)};
    cfg_we = 1'b1;
    master_en = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_wdata = 8'hFF;
    cur_n = n; cur_m = m;
    for (c = 0; c < len; c++) begin
      check_cycle(1'b1, prev_low);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_n = 0; cur_m = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R1 reset samp_stb", samp_stb, 1);
      chk("R1 reset scl_o", scl_o, 1);
      chk("R1 reset edges", scl_rise | scl_fall, 0);
    end
    @(negedge clk);
    for (int n = 0; n < 3; n++)
      for (int m = 0; m < 16; m++)
        run_cfg(n, m, 1'(m), 20 * (m + 1) * (1 << n) + 3);   // R2 R4 R5
    run_cfg(7, 0, 1'b1, 2 * 1280 + 2);
    run_cfg(5, 3, 1'b0, 1280 + 700);
    run_cfg(1, 1, 1'b0, 25);
    run_cfg(0, 2, 1'b1, 70);               // R6 write while SCL low
    run_cfg(1, 1, 1'b0, 25);
    master_en = 1'b0;                       // R7 drop enable while SCL low
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      c++;
      check_cycle(1'b0, 1'b0);
    end
    @(negedge clk);
    run_cfg(2, 4, 1'b1, 2 * 400 + 5);      // R5 clean restart after idle
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule